// File: doc/BRIEF.md
# Cross-Coupled Processor Handshake Register Pair

Two processors that share a chip often need a small, low-latency way to signal each other without going through a message queue. This block holds one 16-bit handshake register for each of two processors, here called side A and side B. Each side has its own write port, with byte-lane enables, and its own read port. Each side publishes a 4-bit code in bits 11:8 of its own register. That code appears in bits 3:0 of the opposite side's register, and the opposite side can only read those bits.

Each side can also ask for attention from the other side. A write that carries bit 13 set raises a request towards the receiver, but only if the receiver has set bit 14 of its own register to allow it. The request arrives as a one-cycle pulse on the receiver's interrupt output. The bits that a write does not store read back as zero. A write that enables only one byte lane combines that byte with the other byte of the current register before the bits are filtered.

The block is meant to sit behind each processor's register decoder. It does not hold the message FIFO, the interrupt controller or any address decoding.

Top module: `ipc_sync_pair`

## Requirements
- R1: A side's register stores only bits 8–11, 13 and 14 from its own writes. Bits 7:4, 12 and 15 always read as zero.
- R2: A side's own writes never change bits 3:0 of its own register, whatever value the write carries in those bits.
- R3: When a side writes, the resulting bits 11:8 of its register are copied into bits 3:0 of the other side's register, and the other side's bits 15:4 stay as they were. The copy is visible on the next cycle.
- R4: A request is qualified when a side writes with bit 13 of the combined write word set and the receiver's current register has bit 14 set. A qualified request drives the receiver's interrupt output (a_irq for side A, b_irq for side B) high for exactly the one cycle after the write's clock edge.
- R5: A write whose combined bit 13 is clear, or a receiver whose bit 14 is clear, leaves the receiver's interrupt output low.
- R6: Byte enable bit 1 selects bits 15:8 and byte enable bit 0 selects bits 7:0. A byte that is not enabled takes its value from the current register before filtering, so a low-byte-only write republishes the stored bits 11:8 and re-fires from the stored bit 13. A write with both byte enables clear has no effect on either register or on either interrupt output.
- R7: Reset, active low, clears both registers to zero and holds both interrupt outputs low.
- R8: When both sides write in the same cycle, both writes take effect. Each side's bits 3:0 take the other side's new bits 11:8. Each request is qualified against the receiver's register value from before that cycle.
- R9: Read data comes combinationally from the register, and reading has no side effects. A write shows on the read port from the cycle after its clock edge, and the value holds while neither side writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_be | input | 2 | Side A byte enables |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A register contents |
| a_irq | output | 1 | One-cycle request pulse towards side A |
| b_wr_en | input | 1 | Side B write strobe |
| b_be | input | 2 | Side B byte enables |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B register contents |
| b_irq | output | 1 | One-cycle request pulse towards side B |

## Verification
Both registers are visible directly on the read ports. A corrupted stored field therefore shows in the first cycle after the faulty write, either in the writer's own read data or in the peer's low nibble. Corrupted enable state stays hidden until the other side fires a request: the pulse then goes missing, or appears when it should not, one cycle after that write. The stimulus sequence is ordered so that every enable bit is exercised by a later request while both of its values are live. Low-byte-only writes are included so that state carried in the unwritten byte is exposed through re-publishing and re-firing.

// File: rtl/ipc_sync_pkg.sv
package ipc_sync_pkg;
   localparam int LANE_W = 8;
   typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} ipc_side_e;
endpackage

// File: rtl/ipc_lane_merge.sv
module ipc_lane_merge #(
   parameter int REG_W = 16,
   parameter logic [REG_W-1:0] KEEP_MASK = '0
) (
   input  logic [REG_W-1:0]                          cur,
   input  logic [REG_W-1:0]                          wdata,
   input  logic [REG_W/ipc_sync_pkg::LANE_W-1:0]     be,
   output logic [REG_W-1:0]                          merged,
   output logic [REG_W-1:0]                          filtered
);
   localparam int LW    = ipc_sync_pkg::LANE_W;
   localparam int LANES = REG_W / LW;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LW +: LW] = be[l] ? wdata[l*LW +: LW] : cur[l*LW +: LW];
   end

   assign filtered = merged & KEEP_MASK;
endmodule

// File: rtl/ipc_sync_side.sv
module ipc_sync_side #(
   parameter int REG_W = 16,
   parameter int PUB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             own_wr,
   input  logic [REG_W-1:0] own_val,
   input  logic             peer_wr,
   input  logic [PUB_W-1:0] peer_code,
   output logic [REG_W-1:0] reg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else begin
         if (own_wr)  reg_q[REG_W-1:PUB_W] <= own_val[REG_W-1:PUB_W];
         if (peer_wr) reg_q[PUB_W-1:0]     <= peer_code;
      end
   end
endmodule

// File: rtl/ipc_irq_gen.sv
module ipc_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic peer_wr,
   input  logic peer_fire,
   input  logic local_arm,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= peer_wr & peer_fire & local_arm;
   end
endmodule

// File: rtl/ipc_sync_pair.sv
module ipc_sync_pair #(
   parameter int REG_W    = 16,
   parameter int PUB_LSB  = 8,
   parameter int PUB_W    = 4,
   parameter int FIRE_BIT = 13,
   parameter int ARM_BIT  = 14
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  a_wr_en,
   input  logic [REG_W/ipc_sync_pkg::LANE_W-1:0] a_be,
   input  logic [REG_W-1:0]                      a_wdata,
   output logic [REG_W-1:0]                      a_rdata,
   output logic                                  a_irq,
   input  logic                                  b_wr_en,
   input  logic [REG_W/ipc_sync_pkg::LANE_W-1:0] b_be,
   input  logic [REG_W-1:0]                      b_wdata,
   output logic [REG_W-1:0]                      b_rdata,
   output logic                                  b_irq
);
   import ipc_sync_pkg::*;

   localparam int LANES = REG_W / LANE_W;
   localparam logic [REG_W-1:0] PUB_MASK  = ((REG_W'(1) << PUB_W) - REG_W'(1)) << PUB_LSB;
   localparam logic [REG_W-1:0] KEEP_MASK = PUB_MASK | (REG_W'(1) << FIRE_BIT) | (REG_W'(1) << ARM_BIT);

   if (REG_W % LANE_W != 0) begin : g_bad_width
      $error("REG_W must be a whole number of byte lanes");
   end
   if (PUB_W > PUB_LSB || PUB_LSB + PUB_W > REG_W) begin : g_bad_pub
      $error("published field must lie above the mirrored field and inside the register");
   end
   if (FIRE_BIT < PUB_W || ARM_BIT < PUB_W || FIRE_BIT >= REG_W || ARM_BIT >= REG_W || FIRE_BIT == ARM_BIT) begin : g_bad_ctl
      $error("control bits must be distinct, in range and above the mirrored field");
   end
   if ((PUB_MASK & ((REG_W'(1) << FIRE_BIT) | (REG_W'(1) << ARM_BIT))) != '0) begin : g_bad_overlap
      $error("control bits overlap the published field");
   end

   logic [1:0]             wr_eff;
   logic [LANES-1:0]       be_v  [2];
   logic [REG_W-1:0]       wd_v  [2];
   logic [REG_W-1:0]       cur_q [2];
   logic [REG_W-1:0]       merged[2];
   logic [REG_W-1:0]       filt  [2];
   logic [1:0]             irq_v;

   assign be_v[SIDE_A] = a_be;
   assign be_v[SIDE_B] = b_be;
   assign wd_v[SIDE_A] = a_wdata;
   assign wd_v[SIDE_B] = b_wdata;
   assign wr_eff[SIDE_A] = a_wr_en & (|a_be);
   assign wr_eff[SIDE_B] = b_wr_en & (|b_be);

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int P = 1 - s;

      ipc_lane_merge #(.REG_W(REG_W), .KEEP_MASK(KEEP_MASK)) u_merge (
         .cur      (cur_q[s]),
         .wdata    (wd_v[s]),
         .be       (be_v[s]),
         .merged   (merged[s]),
         .filtered (filt[s])
      );

      ipc_sync_side #(.REG_W(REG_W), .PUB_W(PUB_W)) u_reg (
         .clk       (clk),
         .rst_n     (rst_n),
         .own_wr    (wr_eff[s]),
         .own_val   (filt[s]),
         .peer_wr   (wr_eff[P]),
         .peer_code (filt[P][PUB_LSB +: PUB_W]),
         .reg_q     (cur_q[s])
      );

      ipc_irq_gen u_irq (
         .clk       (clk),
         .rst_n     (rst_n),
         .peer_wr   (wr_eff[P]),
         .peer_fire (merged[P][FIRE_BIT]),
         .local_arm (cur_q[s][ARM_BIT]),
         .irq       (irq_v[s])
      );
   end

   assign a_rdata = cur_q[SIDE_A];
   assign b_rdata = cur_q[SIDE_B];
   assign a_irq   = irq_v[SIDE_A];
   assign b_irq   = irq_v[SIDE_B];
endmodule

// File: rtl/ipc_sync_chk.sv
module ipc_sync_chk #(
   parameter int REG_W    = 16,
   parameter int PUB_LSB  = 8,
   parameter int PUB_W    = 4,
   parameter int FIRE_BIT = 13,
   parameter int ARM_BIT  = 14
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  a_wr_en,
   input logic [REG_W/ipc_sync_pkg::LANE_W-1:0] a_be,
   input logic [REG_W-1:0]                      a_wdata,
   input logic [REG_W-1:0]                      a_rdata,
   input logic                                  a_irq,
   input logic                                  b_wr_en,
   input logic [REG_W/ipc_sync_pkg::LANE_W-1:0] b_be,
   input logic [REG_W-1:0]                      b_wdata,
   input logic [REG_W-1:0]                      b_rdata,
   input logic                                  b_irq
);
   localparam int LW = ipc_sync_pkg::LANE_W;
   localparam logic [REG_W-1:0] LEGAL =
      (((REG_W'(1) << PUB_W) - REG_W'(1)) << PUB_LSB) |
      ((REG_W'(1) << PUB_W) - REG_W'(1)) |
      (REG_W'(1) << FIRE_BIT) | (REG_W'(1) << ARM_BIT);

   logic a_w, b_w;
   assign a_w = a_wr_en & (|a_be);
   assign b_w = b_wr_en & (|b_be);

   // R1: unstored bits read as zero
   a_r1_clean_a: assert property (@(posedge clk) disable iff (!rst_n) (a_rdata & ~LEGAL) == '0);
   a_r1_clean_b: assert property (@(posedge clk) disable iff (!rst_n) (b_rdata & ~LEGAL) == '0);

   // R2: mirrored field moves only on a peer write
   a_r2_low_a: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(b_w) |-> a_rdata[PUB_W-1:0] == $past(a_rdata[PUB_W-1:0]));
   a_r2_low_b: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(a_w) |-> b_rdata[PUB_W-1:0] == $past(b_rdata[PUB_W-1:0]));

   // R3: published code lands in the peer's mirrored field
   a_r3_copy_ab: assert property (@(posedge clk) disable iff (!rst_n)
      $past(a_w) |-> b_rdata[PUB_W-1:0] == $past(a_be[PUB_LSB/LW] ? a_wdata[PUB_LSB +: PUB_W] : a_rdata[PUB_LSB +: PUB_W]));
   a_r3_copy_ba: assert property (@(posedge clk) disable iff (!rst_n)
      $past(b_w) |-> a_rdata[PUB_W-1:0] == $past(b_be[PUB_LSB/LW] ? b_wdata[PUB_LSB +: PUB_W] : b_rdata[PUB_LSB +: PUB_W]));

   // R4: qualified request pulses the receiver
   a_r4_fire_a: assert property (@(posedge clk) disable iff (!rst_n)
      $past(b_w && (b_be[FIRE_BIT/LW] ? b_wdata[FIRE_BIT] : b_rdata[FIRE_BIT]) && a_rdata[ARM_BIT]) |-> a_irq);
   a_r4_fire_b: assert property (@(posedge clk) disable iff (!rst_n)
      $past(a_w && (a_be[FIRE_BIT/LW] ? a_wdata[FIRE_BIT] : a_rdata[FIRE_BIT]) && b_rdata[ARM_BIT]) |-> b_irq);

   // R5: no pulse without a peer write and a set arm bit
   a_r5_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
      a_irq |-> $past(b_w && a_rdata[ARM_BIT]));
   a_r5_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
      b_irq |-> $past(a_w && b_rdata[ARM_BIT]));

   // R9: upper field holds with no own write
   a_r9_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(a_w) |-> a_rdata[REG_W-1:PUB_W] == $past(a_rdata[REG_W-1:PUB_W]));
   a_r9_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(b_w) |-> b_rdata[REG_W-1:PUB_W] == $past(b_rdata[REG_W-1:PUB_W]));
endmodule

bind ipc_sync_pair ipc_sync_chk #(
   .REG_W(REG_W), .PUB_LSB(PUB_LSB), .PUB_W(PUB_W), .FIRE_BIT(FIRE_BIT), .ARM_BIT(ARM_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .a_wr_en(a_wr_en), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
   .b_wr_en(b_wr_en), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
);

// File: tb/tb_ipc_sync_pair.sv
module tb_ipc_sync_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_wr_en = 1'b0, b_wr_en = 1'b0;
   logic [1:0]  a_be = '0, b_be = '0;
   logic [15:0] a_wdata = '0, b_wdata = '0;
   logic [15:0] a_rdata, b_rdata;
   logic        a_irq, b_irq;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   ipc_sync_pair dut (
      .clk(clk), .rst_n(rst_n),
      .a_wr_en(a_wr_en), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
      .b_wr_en(b_wr_en), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
   );

   typedef struct packed {
      logic        side;   // 0 = A writes, 1 = B writes
      logic [1:0]  be;
      logic [15:0] wdata;
      logic [15:0] exp_a;
      logic [15:0] exp_b;
      logic        exp_ia;
      logic        exp_ib;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'b11, 16'hFFFF, 16'h6F00, 16'h000F, 1'b0, 1'b0}, // R1 R3 R5: B not armed
      '{1'b1, 2'b11, 16'h4A00, 16'h6F0A, 16'h4A0F, 1'b0, 1'b0}, // R3 R5: no fire bit
      '{1'b0, 2'b11, 16'h23F5, 16'h230A, 16'h4A03, 1'b0, 1'b1}, // R2 R4
      '{1'b0, 2'b01, 16'h00FF, 16'h230A, 16'h4A03, 1'b0, 1'b1}, // R6 low lane re-fires
      '{1'b0, 2'b10, 16'h0500, 16'h050A, 16'h4A05, 1'b0, 1'b0}, // R6 high lane
      '{1'b1, 2'b11, 16'h2000, 16'h0500, 16'h2005, 1'b0, 1'b0}, // R5 A not armed
      '{1'b0, 2'b11, 16'h410E, 16'h4100, 16'h2001, 1'b0, 1'b0}, // R2 R3
      '{1'b1, 2'b11, 16'h2C00, 16'h410C, 16'h2C01, 1'b1, 1'b0}, // R4 towards A
      '{1'b1, 2'b00, 16'hFFFF, 16'h410C, 16'h2C01, 1'b0, 1'b0}  // R6 no lanes
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R7: reset state
      @(negedge clk); @(negedge clk);
      chk("R7 a_rdata in reset", a_rdata, 16'h0000);
      chk("R7 b_rdata in reset", b_rdata, 16'h0000);
      chk("R7 irqs in reset", {14'd0, a_irq, b_irq}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].side == 1'b0) begin
            a_wr_en = 1'b1; a_be = VEC[i].be; a_wdata = VEC[i].wdata;
         end else begin
            b_wr_en = 1'b1; b_be = VEC[i].be; b_wdata = VEC[i].wdata;
         end
         @(negedge clk);
         a_wr_en = 1'b0; b_wr_en = 1'b0; a_be = '0; b_be = '0;
         chk($sformatf("R1/R2/R3/R6 vec%0d a_rdata", i), a_rdata, VEC[i].exp_a);
         chk($sformatf("R1/R2/R3/R6 vec%0d b_rdata", i), b_rdata, VEC[i].exp_b);
         chk($sformatf("R4/R5 vec%0d a_irq", i), {15'd0, a_irq}, {15'd0, VEC[i].exp_ia});
         chk($sformatf("R4/R5 vec%0d b_irq", i), {15'd0, b_irq}, {15'd0, VEC[i].exp_ib});
         @(negedge clk);
         // R9: values hold with no write; R4: pulse lasts a single cycle
         chk($sformatf("R9 vec%0d a_rdata hold", i), a_rdata, VEC[i].exp_a);
         chk($sformatf("R9 vec%0d b_rdata hold", i), b_rdata, VEC[i].exp_b);
         chk($sformatf("R4 vec%0d pulse ends", i), {14'd0, a_irq, b_irq}, 16'h0000);
      end

      // R8: both sides write together (A=410C, B=2C01 before)
      a_wr_en = 1'b1; a_be = 2'b11; a_wdata = 16'h6700;
      b_wr_en = 1'b1; b_be = 2'b11; b_wdata = 16'h6900;
      @(negedge clk);
      a_wr_en = 1'b0; b_wr_en = 1'b0; a_be = '0; b_be = '0;
      chk("R8 a_rdata simultaneous", a_rdata, 16'h6709);
      chk("R8 b_rdata simultaneous", b_rdata, 16'h6907);
      chk("R8 a_irq uses old A arm", {15'd0, a_irq}, 16'h0001);
      chk("R8 b_irq uses old B arm", {15'd0, b_irq}, 16'h0000);

      // R4: both armed now, A fires towards B
      a_wr_en = 1'b1; a_be = 2'b10; a_wdata = 16'h2100;
      @(negedge clk);
      a_wr_en = 1'b0; a_be = '0;
      chk("R4 b_irq armed B", {15'd0, b_irq}, 16'h0001);
      chk("R3 b low after A=2100", b_rdata, 16'h6901);

      // R7: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R7 a_rdata after reset", a_rdata, 16'h0000);
      chk("R7 b_rdata after reset", b_rdata, 16'h0000);
      chk("R7 irqs after reset", {14'd0, a_irq, b_irq}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule